// File: doc/BRIEF.md
# Single-Item Coin Vending Controller

This controller runs the money side of a vending machine that sells one kind of item. On every clock it reads a 2-bit code that reports the coin accepted in that cycle and adds the coin's value, in cents, to a running credit. The credit is always visible on an output for a display. Each item costs 80 cents.

When the buyer presses the select button and the credit covers the price, the controller raises a release strobe for one clock cycle. It then takes the price off the credit and keeps the rest for the next purchase. A press made while the credit is short does nothing. A press is a rising edge of the button input, so a button held down buys at most one item. The reset is asynchronous and active low. Its release is assumed to be synchronised outside the block.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the credit output reads 0 and the release output is 0.
- R2: Coin code 2'b01 adds 5, code 2'b10 adds 10 and code 2'b11 adds 25 to the credit. The addition shows on the credit output after the clock edge that samples the code, once for each cycle the code is present. Code 2'b00 adds nothing.
- R3: The credit never wraps. An addition that would pass 255 leaves the credit at 255.
- R4: A press while the credit is below 80 is ignored. The release output stays 0 and the credit changes only by any coin in the same cycle.
- R5: A press while the credit is at least 80 drives the release output to 1 in the cycle after the edge that samples the press, for exactly one cycle.
- R6: On a sale the credit becomes old credit minus 80, plus the value of any coin sampled on the same edge. The remainder is kept.
- R7: A press is a 0-to-1 change of the button between two samples. Holding the button high gives no further release until it has been sampled low and then high again.
- R8: The credit output always shows the credit register, updated once per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coin_code | input | 2 | Coin accepted this cycle (00 none, 01 5c, 10 10c, 11 25c) |
| select_btn | input | 1 | Purchase button, level |
| credit_disp | output | 8 | Current credit in cents |
| release_pulse | output | 1 | One-cycle item release strobe |

## Verification
The hardest case to reach is a press that lands on the same edge as a coin while the credit is near a limit. At 80 this gives a sale with a top-up. Just below 80 the press is ignored even though the coin lifts the credit past the price. Near 255 saturation has to combine correctly with the sale path. The stimulus builds these credit values exactly from mixed coins, then holds the button across the crossing of the price and fires presses together with coins. A behavioural model follows every edge to confirm the result.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CREDIT_W = 8;
  localparam int PRICE_C  = 80;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'b00,
    COIN_FIVE   = 2'b01,
    COIN_TEN    = 2'b10,
    COIN_TWENTY5 = 2'b11
  } coin_e;
endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
  import vend_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int V_LOW = 5,
  parameter int V_MID = 10,
  parameter int V_HIGH = 25
) (
  input  logic [1:0]       code,
  output logic [VAL_W-1:0] value,
  output logic             valid
);
  always_comb begin
    unique case (coin_e'(code))
      COIN_FIVE:    value = VAL_W'(V_LOW);
      COIN_TEN:     value = VAL_W'(V_MID);
      COIN_TWENTY5: value = VAL_W'(V_HIGH);
      default:      value = '0;
    endcase
    valid = (code != 2'b00);
  end
endmodule

// File: rtl/vend_press_edge.sv
module vend_press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic press
);
  logic btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) btn_q <= 1'b0;
    else        btn_q <= btn;
  end

  assign press = btn & ~btn_q;
endmodule

// File: rtl/vend_credit_unit.sv
module vend_credit_unit #(
  parameter int CREDIT_W = 8,
  parameter int PRICE    = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CREDIT_W-1:0] coin_val,
  input  logic                coin_vld,
  input  logic                press,
  output logic [CREDIT_W-1:0] credit,
  output logic                release_q
);
  localparam logic [CREDIT_W-1:0] PRICE_V = CREDIT_W'(PRICE);
  localparam logic [CREDIT_W-1:0] MAX_V   = {CREDIT_W{1'b1}};

  logic                sale;
  logic                credit_en;
  logic [CREDIT_W-1:0] after_sale;
  logic [CREDIT_W:0]   sum;
  logic [CREDIT_W-1:0] credit_d;

  always_comb begin
    sale       = press && (credit >= PRICE_V);
    after_sale = sale ? (credit - PRICE_V) : credit;
    sum        = {1'b0, after_sale} + {1'b0, coin_val};
    credit_d   = sum[CREDIT_W] ? MAX_V : sum[CREDIT_W-1:0];
    credit_en  = sale | coin_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         credit <= '0;
    else if (credit_en) credit <= credit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) release_q <= 1'b0;
    else        release_q <= sale;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W = vend_pkg::CREDIT_W,
  parameter int PRICE    = vend_pkg::PRICE_C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          coin_code,
  input  logic                select_btn,
  output logic [CREDIT_W-1:0] credit_disp,
  output logic                release_pulse
);
  logic [CREDIT_W-1:0] coin_val;
  logic                coin_vld;
  logic                press;

  vend_coin_value #(.VAL_W(CREDIT_W)) u_coin (
    .code (coin_code),
    .value(coin_val),
    .valid(coin_vld)
  );

  vend_press_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .btn  (select_btn),
    .press(press)
  );

  vend_credit_unit #(.CREDIT_W(CREDIT_W), .PRICE(PRICE)) u_credit (
    .clk      (clk),
    .rst_n    (rst_n),
    .coin_val (coin_val),
    .coin_vld (coin_vld),
    .press    (press),
    .credit   (credit_disp),
    .release_q(release_pulse)
  );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int CREDIT_W = 8,
  parameter int PRICE    = 80
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          coin_code,
  input logic                select_btn,
  input logic [CREDIT_W-1:0] credit_disp,
  input logic                release_pulse
);
  localparam int MAXI = (1 << CREDIT_W) - 1;

  function automatic int cents(input logic [1:0] c);
    case (c)
      2'b01:   return 5;
      2'b10:   return 10;
      2'b11:   return 25;
      default: return 0;
    endcase
  endfunction

  function automatic int clamp(input int v);
    return (v > MAXI) ? MAXI : v;
  endfunction

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);

  assert_needs_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> (int'($past(credit_disp)) >= PRICE));

  assert_deduct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> (int'(credit_disp) ==
      clamp(int'($past(credit_disp)) - PRICE + cents($past(coin_code)))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!release_pulse && $past(rst_n)) |->
      (int'(credit_disp) == clamp(int'($past(credit_disp)) + cents($past(coin_code)))));

  assert_press_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> $past(select_btn));
endmodule

bind vend_ctrl vend_ctrl_chk #(.CREDIT_W(CREDIT_W), .PRICE(PRICE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .coin_code    (coin_code),
  .select_btn   (select_btn),
  .credit_disp  (credit_disp),
  .release_pulse(release_pulse)
);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] coin_code = 2'b00;
  logic       select_btn = 1'b0;
  logic [7:0] credit_disp;
  logic       release_pulse;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  int  m_credit = 0;
  bit  m_rel = 0;
  bit  m_btn = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  vend_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .coin_code(coin_code), .select_btn(select_btn),
    .credit_disp(credit_disp), .release_pulse(release_pulse)
  );

  function automatic int cents(input logic [1:0] c);
    return (c == 2'b01) ? 5 : (c == 2'b10) ? 10 : (c == 2'b11) ? 25 : 0;
  endfunction

  // Behavioural reference, one update per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_credit <= 0; m_rel <= 0; m_btn <= 0;
    end else begin
      int c;
      bit s;
      c = m_credit;
      s = select_btn && !m_btn && (c >= 80);
      if (s) c = c - 80;
      c = c + cents(coin_code);
      if (c > 255) c = 255;
      m_credit <= c;
      m_rel    <= s;
      m_btn    <= select_btn;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R8: every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk(cur_req, int'(credit_disp), m_credit, "credit (R8 cycle compare)");
      chk(cur_req, int'(release_pulse), int'(m_rel), "release (cycle compare)");
    end
  end

  task automatic step(input logic [1:0] c, input logic b);
    @(negedge clk);
    coin_code  = c;
    select_btn = b;
  endtask

  task automatic settle;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", int'(credit_disp), 0, "credit in reset");
    chk("R1", int'(release_pulse), 0, "release in reset");
    rst_n = 1'b1;
    step(2'b00, 1'b0);
    settle();
    chk("R1", int'(credit_disp), 0, "credit after reset");

    // R2 coin values: 25+25+25+5 = 80
    cur_req = "R2";
    step(2'b11, 0); step(2'b11, 0); step(2'b11, 0); step(2'b01, 0);
    step(2'b00, 0);
    settle();
    chk("R2", int'(credit_disp), 80, "three 25c and one 5c");

    // R5/R6 press at exactly 80
    cur_req = "R5";
    step(2'b00, 1);
    step(2'b00, 0);
    #1;
    chk("R5", int'(release_pulse), 1, "release after press");
    chk("R6", int'(credit_disp), 0, "credit after sale at 80");
    @(negedge clk); #1;
    chk("R5", int'(release_pulse), 0, "release lasts one cycle");

    // R4 press short at 75 ignored, coin same edge
    cur_req = "R4";
    step(2'b11, 0); step(2'b11, 0); step(2'b11, 0);
    step(2'b10, 1);
    step(2'b00, 0);
    #1;
    chk("R4", int'(release_pulse), 0, "press at 75 ignored");
    chk("R4", int'(credit_disp), 85, "only coin added");

    // R7 hold button high across crossing: no release until re-press
    cur_req = "R7";
    step(2'b00, 1); step(2'b00, 1);
    #1;
    chk("R6", int'(credit_disp), 5, "remainder kept");
    step(2'b11, 1); step(2'b11, 1); step(2'b11, 1); step(2'b11, 1);
    step(2'b00, 1); step(2'b00, 1);
    #1;
    chk("R7", int'(release_pulse), 0, "held button gives no extra release");
    chk("R7", int'(credit_disp), 105, "credit kept while held");
    step(2'b00, 0);
    step(2'b10, 1);
    step(2'b00, 0);
    #1;
    chk("R7", int'(release_pulse), 1, "new edge releases");
    chk("R6", int'(credit_disp), 35, "105-80+10");

    // R3 saturation
    cur_req = "R3";
    for (int i = 0; i < 12; i++) step(2'b11, 0);
    step(2'b00, 0);
    settle();
    chk("R3", int'(credit_disp), 255, "saturated at 255");
    step(2'b01, 0); step(2'b00, 0);
    settle();
    chk("R3", int'(credit_disp), 255, "stays 255");

    // R6 sale from 255 with coin
    cur_req = "R6";
    step(2'b11, 1);
    step(2'b00, 0);
    #1;
    chk("R6", int'(credit_disp), 200, "255-80+25");

    // mixed pattern
    cur_req = "R2";
    for (int i = 0; i < 40; i++) step(2'(i % 4), (i % 7) == 3);
    step(2'b00, 0);
    settle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule